// File: doc/BRIEF.md
# IR Carrier Burst Sequencer with Command FIFO

This block turns a queue of 16-bit command words into an infrared-style waveform. Each word asks for a number of carrier periods. For that many periods the block either emits the carrier or holds its output inactive. The carrier shape comes from one of two compare/period pairs: a primary pair and a shadow pair. Words are consumed strictly in the order they were written. Back-to-back words join with no gap, so a message can be built from alternating marks and spaces.

Software fills an eight-word queue through two data register addresses. Writes to either address land in the same queue. The queue reports its occupancy, an empty flag and a full flag. It raises a level interrupt when its occupancy drops below a programmable threshold, so software knows to refill it. A sticky overflow flag records any write that arrived while the queue was full. The queue can be flushed, but only while the sequencer is stopped.

A second operating mode ignores the queue and emits a continuous carrier from the primary pair.

Top module: `ir_burst_seq`

## Requirements
- R1: A command word holds carrier enable in bit 15, shadow select in bit 14 and the pulse count in bits 13:0. A word with count N lasts N carrier periods. Each period is max+1 clocks long, and the output is high during the first cmp clocks of the period when carrier enable is 1.
- R2: A word with bit 14 set times its burst with the shadow cmp/max pair. A word with bit 14 clear uses the primary pair.
- R3: A word with bit 15 clear lasts exactly as long as the same word with bit 15 set, but the output stays low for the whole burst.
- R4: A word with pulse count 0 is removed from the queue, takes one clock with the output low, and produces no carrier periods.
- R5: Words leave the queue in write order. A write strobe on data index 0 (wr_strobe[0]) and a write strobe on data index 1 (wr_strobe[1]) both append to the same queue.
- R6: fifo_count gives the number of stored words (0 to 8). fifo_empty is high when the count is 0, and fifo_full is high when the count is 8.
- R7: A write while fifo_full is high is discarded and sets overflow. Overflow stays set until an accepted flush.
- R8: low_irq is high exactly while fifo_count is less than trig_lvl.
- R9: fifo_clr empties the queue and clears overflow only while busy is low. While busy is high the flush is ignored.
- R10: The mode input selects behaviour while run is high:
  - mode 0x07 plays the queue.
  - mode 0x03 emits a free-running primary carrier and leaves the queue untouched. Its sample j after start is high when (j+1) mod (max+1) < cmp.
  - Any other mode, or run low, keeps the output low and busy low.
- R11: In queue mode the first stored word starts on the first clock edge with run high. When the queue is empty the output stays low. A word written into an empty running queue starts on the clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 2 | Write strobe per data index (0 and 1) |
| wr_data | input | 16 | Command word to append |
| mode | input | 4 | 0x03 continuous carrier, 0x07 queue playback |
| run | input | 1 | Starts the selected mode |
| fifo_clr | input | 1 | Flush request, honoured only while idle |
| cmp_pri | input | 16 | Primary high time in clocks |
| max_pri | input | 16 | Primary period minus one |
| cmp_shd | input | 16 | Shadow high time in clocks |
| max_shd | input | 16 | Shadow period minus one |
| trig_lvl | input | 4 | Low-water threshold |
| wave_out | output | 1 | Waveform output |
| fifo_count | output | 4 | Stored word count |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| low_irq | output | 1 | Occupancy below threshold |
| overflow | output | 1 | Sticky dropped-write flag |
| busy | output | 1 | Sequencer running |

## Verification
The hardest case to reach from the ports is a burst ending on the same clock edge that the next word is loaded. In that case, period and compare values for two different words meet on one edge, and any off-by-one shows up as a missing or extra clock. The stimulus reaches it by loading random queues of up to eight words while stopped, with random counts (zero included), carrier and shadow bits and short periods. It then starts playback and compares every output clock against a waveform the bench builds from the words. Directed cases add a word pushed into an empty, running queue, flushes attempted while running, overflow writes and the continuous-carrier mode.

// File: rtl/ir_seq_pkg.sv
package ir_seq_pkg;
  localparam int CMD_W = 16;
  localparam int PULSE_W = 14;

  typedef struct packed {
    logic               carrier;
    logic               shadow;
    logic [PULSE_W-1:0] pulses;
  } ir_cmd_t;

  typedef enum logic [3:0] {
    MODE_PLAIN = 4'h3,
    MODE_QUEUE = 4'h7
  } ir_mode_e;
endpackage

// File: rtl/ir_cmd_fifo.sv
module ir_cmd_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          ovf
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_nx, rp_q, rp_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          ovf_q, ovf_nx;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_nx  = wp_q;
    rp_nx  = rp_q;
    cnt_nx = cnt_q;
    ovf_nx = ovf_q;
    if (clr) begin
      wp_nx  = '0;
      rp_nx  = '0;
      cnt_nx = '0;
      ovf_nx = 1'b0;
    end else begin
      if (push_ok) wp_nx = bump(wp_q);
      if (pop_ok)  rp_nx = bump(rp_q);
      if (push & full) ovf_nx = 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_nx = cnt_q + 1'b1;
        2'b01:   cnt_nx = cnt_q - 1'b1;
        default: cnt_nx = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_nx;
      rp_q  <= rp_nx;
      cnt_q <= cnt_nx;
      ovf_q <= ovf_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/ir_burst_ctrl.sv
module ir_burst_ctrl
  import ir_seq_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode,
  input  logic              run,
  input  ir_cmd_t           head,
  input  logic              empty,
  input  logic [TIME_W-1:0] cmp_pri,
  input  logic [TIME_W-1:0] max_pri,
  input  logic [TIME_W-1:0] cmp_shd,
  input  logic [TIME_W-1:0] max_shd,
  output logic              pop,
  output logic              wave,
  output logic              busy
);
  logic               plain_md, queue_md;
  logic               act_q, act_nx, car_q, car_nx, shd_q, shd_nx;
  logic [PULSE_W-1:0] rem_q, rem_nx;
  logic [TIME_W-1:0]  cnt_q, cnt_nx;
  logic               use_shd, last_tick, end_burst;
  logic [TIME_W-1:0]  max_sel, cmp_sel;

  assign plain_md  = run && (mode == MODE_PLAIN);
  assign queue_md  = run && (mode == MODE_QUEUE);
  assign busy      = plain_md | queue_md;
  assign use_shd   = queue_md & shd_q;
  assign max_sel   = use_shd ? max_shd : max_pri;
  assign cmp_sel   = use_shd ? cmp_shd : cmp_pri;
  assign last_tick = (cnt_q >= max_sel);
  assign end_burst = act_q & last_tick & (rem_q == PULSE_W'(1));

  always_comb begin
    act_nx = act_q;
    car_nx = car_q;
    shd_nx = shd_q;
    rem_nx = rem_q;
    cnt_nx = cnt_q;
    pop    = 1'b0;
    if (!busy) begin
      act_nx = 1'b0;
      cnt_nx = '0;
    end else if (plain_md) begin
      act_nx = 1'b0;
      cnt_nx = last_tick ? '0 : cnt_q + 1'b1;
    end else if ((!act_q || end_burst) && !empty) begin
      // load next word on the burst's final edge: no gap between words
      pop    = 1'b1;
      car_nx = head.carrier;
      shd_nx = head.shadow;
      rem_nx = head.pulses;
      cnt_nx = '0;
      act_nx = (head.pulses != '0);
    end else if (act_q) begin
      if (last_tick) begin
        cnt_nx = '0;
        rem_nx = rem_q - 1'b1;
        act_nx = (rem_q != PULSE_W'(1));
      end else begin
        cnt_nx = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      car_q <= 1'b0;
      shd_q <= 1'b0;
      rem_q <= '0;
      cnt_q <= '0;
    end else begin
      act_q <= act_nx;
      car_q <= car_nx;
      shd_q <= shd_nx;
      rem_q <= rem_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign wave = plain_md ? (cnt_q < cmp_pri)
                         : (queue_md & act_q & car_q & (cnt_q < cmp_sel));
endmodule

// File: rtl/ir_burst_seq.sv
module ir_burst_seq
  import ir_seq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        wr_strobe,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic [3:0]        mode,
  input  logic              run,
  input  logic              fifo_clr,
  input  logic [TIME_W-1:0] cmp_pri,
  input  logic [TIME_W-1:0] max_pri,
  input  logic [TIME_W-1:0] cmp_shd,
  input  logic [TIME_W-1:0] max_shd,
  input  logic [CW-1:0]     trig_lvl,
  output logic              wave_out,
  output logic [CW-1:0]     fifo_count,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              low_irq,
  output logic              overflow,
  output logic              busy
);
  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic             seq_pop, clr_ok;
  logic [CMD_W-1:0] head_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign clr_ok = fifo_clr & ~busy;

  ir_cmd_fifo #(.DEPTH(DEPTH), .W(CMD_W)) fifo_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (|wr_strobe),
    .pop   (seq_pop),
    .clr   (clr_ok),
    .din   (wr_data),
    .dout  (head_word),
    .count (fifo_count),
    .empty (fifo_empty),
    .full  (fifo_full),
    .ovf   (overflow)
  );

  ir_burst_ctrl #(.TIME_W(TIME_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode    (mode),
    .run     (run),
    .head    (ir_cmd_t'(head_word)),
    .empty   (fifo_empty),
    .cmp_pri (cmp_pri),
    .max_pri (max_pri),
    .cmp_shd (cmp_shd),
    .max_shd (max_shd),
    .pop     (seq_pop),
    .wave    (wave_out),
    .busy    (busy)
  );

  assign low_irq = (fifo_count < trig_lvl);
endmodule

// File: rtl/ir_burst_seq_chk.sv
module ir_burst_seq_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    wr_strobe,
  input logic          fifo_clr,
  input logic          busy,
  input logic          pop,
  input logic          wave_out,
  input logic [CW-1:0] fifo_count,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          overflow
);
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !fifo_empty);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pop && !(fifo_clr && !busy)) |=> fifo_full);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(fifo_clr && !busy)) |=> overflow);

  assert_clr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fifo_clr && (wr_strobe == 2'b00) && !pop) |=> $stable(fifo_count));

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wave_out);
endmodule

bind ir_burst_seq ir_burst_seq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_strobe  (wr_strobe),
  .fifo_clr   (fifo_clr),
  .busy       (busy),
  .pop        (seq_pop),
  .wave_out   (wave_out),
  .fifo_count (fifo_count),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .overflow   (overflow)
);

// File: tb/ir_burst_seq_tb_top.sv
module ir_burst_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  wr_strobe;
  logic [15:0] wr_data;
  logic [3:0]  mode;
  logic        run, fifo_clr;
  logic [15:0] cmp_pri, max_pri, cmp_shd, max_shd;
  logic [3:0]  trig_lvl;
  logic        wave_out, fifo_empty, fifo_full, low_irq, overflow, busy;
  logic [3:0]  fifo_count;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit idx_t = 0;
  bit exp_bits [0:1023];
  int exp_len;

  always #10 clk = ~clk;

  ir_burst_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .mode(mode), .run(run), .fifo_clr(fifo_clr),
    .cmp_pri(cmp_pri), .max_pri(max_pri), .cmp_shd(cmp_shd), .max_shd(max_shd),
    .trig_lvl(trig_lvl), .wave_out(wave_out), .fifo_count(fifo_count),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .low_irq(low_irq),
    .overflow(overflow), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [15:0] w);
    wr_strobe = idx_t ? 2'b10 : 2'b01;
    wr_data   = w;
    idx_t     = ~idx_t;
    @(negedge clk);
    wr_strobe = 2'b00;
  endtask

  task automatic add_word(input logic [15:0] w);
    int m, c;
    m = int'(w[14] ? max_shd : max_pri);
    c = int'(w[14] ? cmp_shd : cmp_pri);
    if (w[13:0] == 14'd0) begin
      exp_bits[exp_len] = 1'b0;
      exp_len++;
    end else begin
      for (int p = 0; p < int'(w[13:0]); p++)
        for (int k = 0; k <= m; k++) begin
          exp_bits[exp_len] = w[15] && (k < c);
          exp_len++;
        end
    end
  endtask

  task automatic play_stream(input string req);
    mode = 4'h7;
    run  = 1'b1;
    for (int i = 0; i < exp_len + 3; i++) begin
      @(negedge clk);
      chk(req, int'(wave_out), (i < exp_len) ? int'(exp_bits[i]) : 0);
    end
    run = 1'b0;
    @(negedge clk);
    chk("R5 drained", int'(fifo_count), 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_strobe = 2'b00; wr_data = '0; mode = 4'h7; run = 1'b0;
    fifo_clr = 1'b0; cmp_pri = 16'd1; max_pri = 16'd2; cmp_shd = 16'd2;
    max_shd = 16'd3; trig_lvl = 4'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R6 reset count", int'(fifo_count), 0);
    chk("R6 reset empty", int'(fifo_empty), 1);
    chk("R6 reset full", int'(fifo_full), 0);
    chk("R7 reset overflow", int'(overflow), 0);
    chk("R8 reset irq", int'(low_irq), 1);
    chk("R10 reset wave", int'(wave_out), 0);

    // R6 R7 R8: fill, overflow, low-water, flush while stopped
    trig_lvl = 4'd3;
    for (int n = 1; n <= 8; n++) begin
      push(16'h8001);
      chk("R6 count", int'(fifo_count), n);
      chk("R8 irq", int'(low_irq), (n < 3) ? 1 : 0);
      chk("R6 full", int'(fifo_full), (n == 8) ? 1 : 0);
    end
    push(16'h8005);
    chk("R7 dropped count", int'(fifo_count), 8);
    chk("R7 overflow set", int'(overflow), 1);
    push(16'h8005);
    chk("R7 overflow sticky", int'(overflow), 1);
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    chk("R9 idle flush count", int'(fifo_count), 0);
    chk("R7 flush clears overflow", int'(overflow), 0);

    // R10 plain mode: queue untouched, flush ignored while busy
    push(16'h8003); push(16'h8003);
    max_pri = 16'd3; cmp_pri = 16'd2;
    mode = 4'h3; run = 1'b1;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      chk("R10 plain wave", int'(wave_out), (((j + 1) % 4) < 2) ? 1 : 0);
    end
    chk("R10 plain queue untouched", int'(fifo_count), 2);
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    chk("R9 busy flush ignored", int'(fifo_count), 2);
    // R10 unknown mode: idle
    mode = 4'h0;
    repeat (3) begin
      @(negedge clk);
      chk("R10 bad mode wave", int'(wave_out), 0);
      chk("R10 bad mode busy", int'(busy), 0);
    end
    chk("R10 bad mode queue", int'(fifo_count), 2);
    run = 1'b0;
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
    chk("R9 flush", int'(fifo_count), 0);

    // R1 R2 R3 R4 R5 directed stream: carrier, shadow, space, zero count
    max_pri = 16'd2; cmp_pri = 16'd1; max_shd = 16'd3; cmp_shd = 16'd3;
    exp_len = 0;
    push(16'h8002); add_word(16'h8002);
    push(16'hC001); add_word(16'hC001);
    push(16'h0000); add_word(16'h0000);
    push(16'h4002); add_word(16'h4002);
    push(16'h8001); add_word(16'h8001);
    play_stream("R1 R2 R3 R4 R5 directed wave");

    // R11: word pushed into empty running queue
    mode = 4'h7; run = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R11 empty running wave", int'(wave_out), 0);
    end
    exp_len = 0;
    push(16'h8002); add_word(16'h8002);
    chk("R11 not yet started wave", int'(wave_out), 0);
    chk("R11 waiting count", int'(fifo_count), 1);
    for (int i = 0; i < exp_len + 2; i++) begin
      @(negedge clk);
      chk("R11 resume wave", int'(wave_out), (i < exp_len) ? int'(exp_bits[i]) : 0);
    end
    run = 1'b0;
    @(negedge clk);

    // random queues
    for (int it = 0; it < 12; it++) begin
      int nw;
      logic [15:0] w;
      max_pri = 16'($urandom_range(0, 4)); cmp_pri = 16'($urandom_range(0, 5));
      max_shd = 16'($urandom_range(0, 4)); cmp_shd = 16'($urandom_range(0, 5));
      trig_lvl = 4'($urandom_range(0, 8));
      nw = $urandom_range(1, 8);
      exp_len = 0;
      for (int k = 0; k < nw; k++) begin
        w = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             14'($urandom_range(0, 3))};
        push(w); add_word(w);
      end
      chk("R6 random count", int'(fifo_count), nw);
      chk("R6 random full", int'(fifo_full), (nw == 8) ? 1 : 0);
      chk("R8 random irq", int'(low_irq), (nw < int'(trig_lvl)) ? 1 : 0);
      play_stream("R1 R2 R3 R4 R11 random wave");
      chk("R6 random empty", int'(fifo_empty), 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule